// File: doc/BRIEF.md
# Multi-mode 8-bit compare timer

This block is an 8-bit up-counter with a prescaled count rate and two 8-bit compare values. It drives one output pin and one interrupt request pulse. A small write-strobe register file selects the operating mode. The block has three modes:

- **Interval.** The pin toggles on every period, so it gives a square wave.
- **PWM.** One compare value sets the period and the other sets the duty point.
- **Carrier generation.** The counter alternates between the two compare values to form a carrier with independent high and low times. That carrier is gated by a latched level, loaded from a buffer bit whenever an external timer pulses an event strobe.

Compare value 0 defines the period in every mode, and each match with it raises the interrupt request. Compare value 0 is locked while the timer runs. A write attempted during counting is dropped and leaves a sticky error flag that software can read. The count rate comes from a free-running divider inside the block. Its slowest tap is chosen by a build parameter: either the system clock divided by 1024, or a low-speed tick input divided by 2048.

Top module: `cmp_timer8`

## Requirements
- R1: After reset, all four registers read 0x00, the output pin is 0 and the interrupt request is 0.
- R2: In every mode, the interrupt request is a single-cycle pulse, raised once for each count tick on which the counter equals compare value 0. While the counter runs against compare value 0, successive pulses are (cmp0+1) count ticks apart.
- R3: Clock select (mode register bits 6:4) sets the count tick rate:
  - 0: every clock
  - 1: every 2 clocks
  - 2: every 4 clocks
  - 3: every 16 clocks
  - 4: every 64 clocks
  - 5: the slow tap, every 1024 clocks with the default build
  - 6 and 7: no ticks, so the count stops
- R4: Interval mode (mode field bits 3:2 = 00): a match with compare value 0 returns the counter to 0 on that tick and inverts the output flip-flop, so the pin stays at each level for (cmp0+1) ticks.
- R5: PWM mode (mode field = 01): the period is (cmp0+1) ticks. The pin takes the level opposite to the idle bit when the counter wraps on a compare-0 match. It returns to the idle level on the tick where the counter equals compare value 1, so the active time is (cmp1+1) ticks.
- R6: Carrier mode (mode field = 10): the counter runs to compare value 0, then to compare value 1, then repeats, clearing and toggling the carrier on each match. The carrier is low for (cmp0+1) ticks and high for (cmp1+1) ticks. The pin equals (carrier AND gate latch) XOR polarity, where polarity is carrier register bit 1.
- R7: The gate latch resets to 0. It changes only on a cycle where the event strobe is high, and it then takes carrier register bit 0.
- R8: Writing compare value 0 while the enable bit is 1 leaves the stored value unchanged and sets the error flag, carrier register bit 7. The flag is read-only and stays set until reset.
- R9: With output enable (mode bit 0) at 0, the pin shows the idle bit (mode bit 1) while the counter keeps running.
- R10: Clearing the enable bit (mode bit 7) clears the counter and returns the pin to the idle level. After re-enabling with clock select 0, the first interrupt pulse is visible (cmp0+1) clocks after the enabling write edge.
- R11: Mode field code 11 behaves exactly as interval mode.
- R12: Register map, addressed by wr_addr and rd_addr:
  - 0: the mode register. Bit 7 is enable, bits 6:4 clock select, bits 3:2 mode, bit 1 idle level and bit 0 output enable. It reads back as written.
  - 1: compare value 0.
  - 2: compare value 1, which is writable at any time.
  - 3: the carrier register. Bit 0 is the gate buffer, bit 1 is polarity and bit 7 is the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the fastest count rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ls_tick | input | 1 | Low-speed tick strobe used by the optional slow tap |
| evt_in | input | 1 | Event strobe from an external timer, loads the gate latch |
| tmr_out | output | 1 | Timer output pin |
| tmr_irq | output | 1 | Interrupt request pulse |

## Verification
- **Write timing.** A register write takes effect on the clock edge that captures the strobe.
- **Interrupt timing.** The interrupt request is registered, so it appears one clock after the tick that matched.
- **Pin timing.** The pin follows the output flip-flop within the same cycle.
- **Sampling.** The bench samples on falling edges and measures durations between observed events: pulse-to-pulse spacing, and level times between pin transitions. These durations are independent of the free-running prescaler phase.
- **Restart latency.** Where an absolute latency is fixed, as after re-enabling with clock select 0, the check counts falling edges from the enabling write and expects the pulse on the (cmp0+1)-th.
- **Stopped clock selects.** Codes 6 and 7 are checked by observing no pulse over a window far longer than any period.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

    localparam int CNT_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_TAP = 5;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t ADDR_MODE = 2'd0;
    localparam addr_t ADDR_CMP0 = 2'd1;
    localparam addr_t ADDR_CMP1 = 2'd2;
    localparam addr_t ADDR_CAR  = 2'd3;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_PWM      = 2'b01,
        MODE_CARRIER  = 2'b10,
        MODE_RSVD     = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic       enable;
        logic [2:0] clk_sel;
        tmr_mode_e  mode;
        logic       idle_lvl;
        logic       out_en;
    } mode_reg_t;

    typedef struct packed {
        logic pol;
        logic nrz_buf;
    } car_reg_t;

    // Divider exponent of each fast tap, indexed by clock select code.
    function automatic int tap_exp(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 4;
            default: return 6;
        endcase
    endfunction

    function automatic tmr_mode_e effective_mode(input tmr_mode_e m);
        return (m == MODE_RSVD) ? MODE_INTERVAL : m;
    endfunction

endpackage

// File: rtl/timer8_prescaler.sv
module timer8_prescaler
    import timer8_pkg::*;
#(
    parameter int DIV_W        = 10,
    parameter int LS_W         = 11,
    parameter bit SLOW_FROM_LS = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ls_tick,
    input  logic [2:0] clk_sel,
    output logic       tick
);

    logic [DIV_W-1:0]   div_q;
    logic [LS_W-1:0]    ls_q;
    logic [NUM_TAP-1:0] tap;
    logic               slow_fast;
    logic               slow_ls;
    logic               slow_tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            ls_q  <= '0;
        end else begin
            div_q <= div_q + 1'b1;
            if (ls_tick) ls_q <= ls_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_TAP; i++) begin : g_tap
        localparam int K = tap_exp(i);
        if (K == 0) begin : g_full
            assign tap[i] = 1'b1;
        end else begin : g_div
            assign tap[i] = &div_q[K-1:0];
        end
    end

    assign slow_fast = &div_q;
    assign slow_ls   = ls_tick & (&ls_q);
    assign slow_tap  = SLOW_FROM_LS ? slow_ls : slow_fast;

    always_comb begin
        case (clk_sel)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: tick = tap[clk_sel];
            3'd5:                         tick = slow_tap;
            default:                      tick = 1'b0;
        endcase
    end

    // With a divide-by-4 tap, ticks never land on consecutive cycles.
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && clk_sel == 3'd2) |=> (!tick || clk_sel != 3'd2));

endmodule

// File: rtl/timer8_regs.sv
module timer8_regs
    import timer8_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  addr_t     wr_addr,
    input  cnt_t      wr_data,
    input  addr_t     rd_addr,
    output cnt_t      rd_data,
    output mode_reg_t mode_q,
    output cnt_t      cmp0_q,
    output cnt_t      cmp1_q,
    output car_reg_t  car_q
);

    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cmp0_q <= '0;
            cmp1_q <= '0;
            car_q  <= '0;
            err_q  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE: mode_q <= mode_reg_t'(wr_data);
                ADDR_CMP0: begin
                    if (!mode_q.enable) cmp0_q <= wr_data;
                    else                err_q  <= 1'b1;
                end
                ADDR_CMP1: cmp1_q <= wr_data;
                default:   car_q  <= car_reg_t'(wr_data[1:0]);
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_MODE: rd_data = cnt_t'(mode_q);
            ADDR_CMP0: rd_data = cmp0_q;
            ADDR_CMP1: rd_data = cmp1_q;
            default:   rd_data = {err_q, 5'b0, car_q};
        endcase
    end

    assert_cmp0_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CMP0 && mode_q.enable) |=> ($stable(cmp0_q) && err_q));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/timer8_core.sv
module timer8_core
    import timer8_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  mode_reg_t mode_q,
    input  cnt_t      cmp0_q,
    input  cnt_t      cmp1_q,
    input  car_reg_t  car_q,
    input  logic      evt_in,
    output logic      tmr_out,
    output logic      tmr_irq
);

    tmr_mode_e mode_e;
    cnt_t      cnt_q;
    cnt_t      target;
    logic      flop_q;
    logic      phase_q;
    logic      nrz_q;
    logic      irq_q;
    logic      carrier;
    logic      hit;
    logic      hit0;
    logic      hit1_pwm;

    assign mode_e   = effective_mode(mode_q.mode);
    assign carrier  = (mode_e == MODE_CARRIER);
    assign target   = (carrier && phase_q) ? cmp1_q : cmp0_q;
    assign hit      = mode_q.enable && tick && (cnt_q == target);
    assign hit0     = hit && !(carrier && phase_q);
    assign hit1_pwm = mode_q.enable && tick && (mode_e == MODE_PWM)
                      && (cnt_q == cmp1_q) && !hit0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            flop_q  <= 1'b0;
            phase_q <= 1'b0;
            nrz_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= hit0;
            if (evt_in) nrz_q <= car_q.nrz_buf;
            if (!mode_q.enable) begin
                cnt_q   <= '0;
                flop_q  <= 1'b0;
                phase_q <= 1'b0;
            end else begin
                if (!carrier) phase_q <= 1'b0;
                if (tick) begin
                    cnt_q <= hit ? '0 : cnt_q + 1'b1;
                    case (mode_e)
                        MODE_PWM: begin
                            if (hit0)          flop_q <= 1'b1;
                            else if (hit1_pwm) flop_q <= 1'b0;
                        end
                        MODE_CARRIER: begin
                            if (hit) begin
                                flop_q  <= ~flop_q;
                                phase_q <= ~phase_q;
                            end
                        end
                        default: begin
                            if (hit0) flop_q <= ~flop_q;
                        end
                    endcase
                end
            end
        end
    end

    always_comb begin
        if (!mode_q.out_en) tmr_out = mode_q.idle_lvl;
        else if (carrier)   tmr_out = (flop_q & nrz_q) ^ car_q.pol;
        else                tmr_out = flop_q ^ mode_q.idle_lvl;
    end

    assign tmr_irq = irq_q;

    assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        tmr_irq |-> $past(mode_q.enable));

    assert_clear_on_disable_R10: assert property (@(posedge clk) disable iff (rst)
        !mode_q.enable |=> (cnt_q == '0 && !flop_q));

    assert_interval_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q.enable && mode_e == MODE_INTERVAL && !phase_q) |-> (cnt_q <= cmp0_q));

    assert_nrz_load_R7: assert property (@(posedge clk) disable iff (rst)
        evt_in |=> (nrz_q == $past(car_q.nrz_buf)));

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
    import timer8_pkg::*;
#(
    parameter int DIV_W        = 10,
    parameter int LS_W         = 11,
    parameter bit SLOW_FROM_LS = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        ls_tick,
    input  logic        evt_in,
    output logic        tmr_out,
    output logic        tmr_irq
);

    mode_reg_t mode_q;
    cnt_t      cmp0_q;
    cnt_t      cmp1_q;
    car_reg_t  car_q;
    logic      tick;

    timer8_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .mode_q  (mode_q),
        .cmp0_q  (cmp0_q),
        .cmp1_q  (cmp1_q),
        .car_q   (car_q)
    );

    timer8_prescaler #(
        .DIV_W        (DIV_W),
        .LS_W         (LS_W),
        .SLOW_FROM_LS (SLOW_FROM_LS)
    ) u_presc (
        .clk     (clk),
        .rst     (rst),
        .ls_tick (ls_tick),
        .clk_sel (mode_q.clk_sel),
        .tick    (tick)
    );

    timer8_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode_q  (mode_q),
        .cmp0_q  (cmp0_q),
        .cmp1_q  (cmp1_q),
        .car_q   (car_q),
        .evt_in  (evt_in),
        .tmr_out (tmr_out),
        .tmr_irq (tmr_irq)
    );

endmodule

// File: tb/cmp_timer8_bench.sv
`timescale 1ns/1ps
module cmp_timer8_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ls_tick = 1'b0;
    logic       evt_in = 1'b0;
    logic       tmr_out;
    logic       tmr_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cmp_timer8 u_cmp_timer8 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ls_tick(ls_tick), .evt_in(evt_in),
        .tmr_out(tmr_out), .tmr_irq(tmr_irq)
    );

    function automatic logic [7:0] mb(input bit en, input int sel, input int md,
                                      input bit idle, input bit oe);
        return {en, sel[2:0], md[1:0], idle, oe};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_irq(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tmr_irq && n < lim);
        if (!tmr_irq) n = -1;
    endtask

    task automatic wait_pin(input logic lvl, input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tmr_out !== lvl && n < lim);
        if (tmr_out !== lvl) n = -1;
    endtask

    task automatic irq_period(input int lim, output int p);
        int s;
        wait_irq(lim, s);
        wait_irq(lim, p);
    endtask

    task automatic pin_high_time(input int lim, output int h);
        int s;
        wait_pin(1'b0, lim, s);
        wait_pin(1'b1, lim, s);
        wait_pin(1'b0, lim, h);
    endtask

    task automatic pin_low_time(input int lim, output int l);
        int s;
        wait_pin(1'b1, lim, s);
        wait_pin(1'b0, lim, s);
        wait_pin(1'b1, lim, l);
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
    endtask

    task automatic stop_timer();
        wr(2'd0, 8'h00);
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 register reset", v, 0);
        end
        check("R1 pin reset", int'(tmr_out), 0);
        check("R1 irq reset", int'(tmr_irq), 0);
    endtask

    task automatic t_interval();
        int v;
        int p;
        wr(2'd1, 8'd4);
        wr(2'd0, mb(1, 0, 0, 0, 1));
        rd(2'd0, v);
        check("R12 mode readback", v, int'(mb(1, 0, 0, 0, 1)));
        irq_period(100, p);
        check("R2 irq period", p, 5);
        @(negedge clk);
        check("R2 irq single cycle", int'(tmr_irq), 0);
        pin_high_time(100, p);
        check("R4 interval pin high time", p, 5);
        pin_low_time(100, p);
        check("R4 interval pin low time", p, 5);
    endtask

    task automatic t_lock();
        int v;
        int p;
        wr(2'd1, 8'd9);
        rd(2'd1, v);
        check("R8 cmp0 write ignored", v, 4);
        rd(2'd3, v);
        check("R8 error flag set", v, 8'h80);
        irq_period(100, p);
        check("R8 period unchanged", p, 5);
        rd(2'd3, v);
        check("R8 error flag sticky", v, 8'h80);
    endtask

    task automatic t_disable();
        int n;
        wr(2'd0, mb(0, 0, 0, 1, 1));
        @(negedge clk);
        check("R10 pin idle when disabled", int'(tmr_out), 1);
        wr(2'd0, mb(1, 0, 0, 1, 1));
        wait_irq(100, n);
        check("R10 restart latency", n, 5);
        check("R10 pin toggled from idle", int'(tmr_out), 0);
    endtask

    task automatic t_out_enable();
        int bad = 0;
        int p;
        stop_timer();
        wr(2'd0, mb(1, 0, 0, 1, 0));
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tmr_out !== 1'b1) bad++;
        end
        check("R9 pin holds idle level", bad, 0);
        irq_period(100, p);
        check("R9 counter still runs", p, 5);
    endtask

    task automatic t_clk_sel(input int sel, input int cmp, input int exp);
        int p;
        stop_timer();
        wr(2'd1, cmp[7:0]);
        wr(2'd0, mb(1, sel, 0, 0, 1));
        if (exp < 0) begin
            wait_irq(300, p);
        end else begin
            irq_period(exp * 3, p);
        end
        check($sformatf("R3 clock select %0d", sel), p, exp);
    endtask

    task automatic t_pwm();
        int p;
        stop_timer();
        wr(2'd1, 8'd9);
        wr(2'd2, 8'd3);
        wr(2'd0, mb(1, 0, 1, 0, 1));
        irq_period(100, p);
        check("R5 pwm period", p, 10);
        pin_high_time(100, p);
        check("R5 pwm active time", p, 4);
        pin_low_time(100, p);
        check("R5 pwm inactive time", p, 6);
        wr(2'd2, 8'd6);
        pin_high_time(100, p);
        check("R12 cmp1 written while running", p, 7);
    endtask

    task automatic t_reserved();
        int p;
        stop_timer();
        wr(2'd1, 8'd2);
        wr(2'd0, mb(1, 0, 3, 0, 1));
        pin_high_time(100, p);
        check("R11 reserved mode high time", p, 3);
        irq_period(100, p);
        check("R11 reserved mode period", p, 3);
    endtask

    task automatic t_carrier();
        int p;
        int bad = 0;
        stop_timer();
        wr(2'd1, 8'd2);
        wr(2'd2, 8'd4);
        wr(2'd3, 8'h01);
        wr(2'd0, mb(1, 0, 2, 0, 1));
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tmr_out !== 1'b0) bad++;
        end
        check("R7 gate closed before strobe", bad, 0);
        pulse_evt();
        pin_high_time(100, p);
        check("R6 carrier high time", p, 5);
        pin_low_time(100, p);
        check("R6 carrier low time", p, 3);
        irq_period(100, p);
        check("R2 carrier irq period", p, 8);
        wr(2'd3, 8'h02);
        pin_low_time(100, p);
        check("R6 inverted carrier low time", p, 5);
        pulse_evt();
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tmr_out !== 1'b1) bad++;
        end
        check("R7 gate reloaded to 0", bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_interval();
        t_lock();
        t_disable();
        t_out_enable();
        t_clk_sel(1, 3, 8);
        t_clk_sel(2, 4, 20);
        t_clk_sel(3, 1, 32);
        t_clk_sel(4, 0, 64);
        t_clk_sel(5, 0, 1024);
        t_clk_sel(6, 0, -1);
        t_clk_sel(7, 0, -1);
        t_pwm();
        t_reserved();
        t_carrier();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule